// File: doc/BRIEF.md
# Ethernet Receive Frame Status Generator

This block follows one received Ethernet frame at a time and produces a status word when the frame closes. A byte stream arrives with a start marker on the first byte and an end marker on the last. The block runs its own CRC-32 over every byte, including the trailing frame check sequence, and counts the frame length. It keeps sticky copies of the MII receive-error input and the buffer-overflow input for the whole frame. At the end byte it combines these with the address-match results, the monitor-mode control and a dribble (odd-nibble) indication to classify the frame.

The status has six flags and a one-cycle valid strobe. The flags depend on one another. A short frame hides a CRC mismatch. A receive error raises the CRC error. An alignment error needs both a CRC error and a frame that did not end on a byte boundary. Address recognition, hash filtering, buffering and host transfer are done elsewhere, and their results come in as inputs.

Top module: `rx_frame_status`

## Requirements
- R1: The CRC is IEEE 802.3 CRC-32 (polynomial 0x04C11DB7, preset all ones, bits taken LSB first) over all bytes of the frame, FCS included. A frame of 64 bytes or more whose register does not end at the fixed residue (0xC704DD7B in normal bit order) reports st_crc_err=1.
- R2: A frame shorter than 64 bytes, FCS included, is a runt. A CRC mismatch on a runt leaves st_crc_err=0.
- R3: If rx_mii_err is high in any cycle from the start byte through the end byte of the frame, st_crc_err=1, runts included.
- R4: st_align_err=1 exactly when st_crc_err=1 and rx_dribble is high with the end byte.
- R5: st_missed=1 when rx_buf_ovf was high in any cycle from the start byte through the end byte. It is also 1 when rx_addr_match and mon_mode are high with the end byte and the frame is neither a runt nor has st_crc_err set.
- R6: st_intact=1 exactly when rx_addr_match is high and mon_mode is low with the end byte, no overflow was seen, the frame is not a runt and st_crc_err=0.
- R7: st_bcast and st_mcast repeat rx_addr_bcast and rx_addr_mcast as sampled with the end byte.
- R8: st_valid is high for exactly the one cycle after the clock edge that takes the end byte. The flags keep their values until the cycle after a new start byte, when all six read 0 (unless that byte is also the end byte).
- R9: Bytes with rx_valid low have no effect. A byte without rx_sof outside a frame has no effect, and neither does an end marker with no open frame. A start byte inside an open frame restarts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A byte is present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_dribble | input | 1 | Frame ended off a byte boundary (sampled with end byte) |
| rx_mii_err | input | 1 | MII receive-error indication |
| rx_buf_ovf | input | 1 | Receive buffer space exhausted |
| rx_addr_match | input | 1 | Destination address recognized (sampled with end byte) |
| rx_addr_bcast | input | 1 | Destination is broadcast (sampled with end byte) |
| rx_addr_mcast | input | 1 | Multicast destination passed hash filter (sampled with end byte) |
| mon_mode | input | 1 | Monitor mode: recognized frames are not stored |
| st_valid | output | 1 | One-cycle status strobe |
| st_bcast | output | 1 | Broadcast flag |
| st_mcast | output | 1 | Multicast flag |
| st_missed | output | 1 | Missed-packet flag |
| st_crc_err | output | 1 | CRC error flag |
| st_align_err | output | 1 | Frame alignment error flag |
| st_intact | output | 1 | Packet received intact flag |

## Verification
The hardest case to reach from the ports is the interaction at the 64-byte edge. There, a frame with a correct FCS, a frame with one flipped bit and a frame carrying a receive error must each land on the right side of the runt rule. Random payloads only rarely hit exactly 63 or 64 bytes with the wanted error mix. So the stimulus drives those lengths directly, with good and corrupted checksums and a receive error placed on the start byte or the end byte. It also builds random frames whose FCS the bench computes, with idle gaps, stray end markers and single-bit corruption mixed in.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;

  // Reflected form of the 802.3 generator, used for LSB-first shifting.
  localparam logic [31:0] RXFS_POLY_REFL = 32'hEDB88320;

  function automatic logic [31:0] rxfs_bitrev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // Residue in normal bit order is 0xC704DD7B; the shift register holds it reflected.
  localparam logic [31:0] RXFS_RESIDUE = rxfs_bitrev32(32'hC704DD7B);

  function automatic logic [31:0] rxfs_crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ RXFS_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  typedef struct packed {
    logic intact;
    logic align_err;
    logic crc_err;
    logic missed;
    logic mcast;
    logic bcast;
  } rxfs_status_t;

endpackage

// File: rtl/rxfs_rst_sync.sv
module rxfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rxfs_frame_track.sv
module rxfs_frame_track #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             sof,
  input  logic             eof,
  input  logic             mii_err,
  input  logic             buf_ovf,
  output logic             start,
  output logic             take,
  output logic             finish,
  output logic [CNT_W-1:0] len_next,
  output logic             err_next,
  output logic             ovf_next
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             in_frame_q, in_frame_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             ovf_q, ovf_d;
  logic             live;

  assign start  = byte_vld && sof;
  assign take   = byte_vld && (sof || in_frame_q);
  assign finish = take && eof;
  assign live   = start || in_frame_q;

  always_comb begin
    in_frame_d = in_frame_q;
    if (finish)     in_frame_d = 1'b0;
    else if (start) in_frame_d = 1'b1;

    cnt_d = cnt_q;
    if (start)                      cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
    else if (take && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;

    err_d = err_q;
    ovf_d = ovf_q;
    if (start) begin
      err_d = mii_err;
      ovf_d = buf_ovf;
    end else if (live) begin
      err_d = err_q | mii_err;
      ovf_d = ovf_q | buf_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      err_q      <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      in_frame_q <= in_frame_d;
      if (take) cnt_q <= cnt_d;
      if (live) begin
        err_q <= err_d;
        ovf_q <= ovf_d;
      end
    end
  end

  assign len_next = cnt_d;
  assign err_next = err_d;
  assign ovf_next = ovf_d;
endmodule

// File: rtl/rxfs_crc32.sv
module rxfs_crc32
  import rxfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       take,
  input  logic [7:0] data,
  output logic       crc_ok
);
  logic [31:0] crc_q, crc_d, seed;

  always_comb begin
    seed  = start ? 32'hFFFFFFFF : crc_q;
    crc_d = rxfs_crc_byte(seed, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= 32'hFFFFFFFF;
    else if (take) crc_q <= crc_d;
  end

  assign crc_ok = (crc_d == RXFS_RESIDUE);
endmodule

// File: rtl/rxfs_classify.sv
module rxfs_classify
  import rxfs_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             finish,
  input  logic [CNT_W-1:0] len_next,
  input  logic             crc_ok,
  input  logic             err_seen,
  input  logic             ovf_seen,
  input  logic             dribble,
  input  logic             addr_match,
  input  logic             addr_bcast,
  input  logic             addr_mcast,
  input  logic             mon_mode,
  output logic             st_valid,
  output rxfs_status_t     status
);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_LEN);

  rxfs_status_t stat_q, stat_d, calc;
  logic         valid_q;
  logic         runt, clean;

  always_comb begin
    runt           = len_next < MIN_CNT;
    calc.crc_err   = err_seen || (!runt && !crc_ok);
    calc.align_err = calc.crc_err && dribble;
    clean          = !runt && !calc.crc_err;
    calc.missed    = ovf_seen || (addr_match && mon_mode && clean);
    calc.intact    = addr_match && !mon_mode && !ovf_seen && clean;
    calc.bcast     = addr_bcast;
    calc.mcast     = addr_mcast;

    stat_d = stat_q;
    if (finish)     stat_d = calc;
    else if (start) stat_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= finish;
      if (finish || start) stat_q <= stat_d;
    end
  end

  assign st_valid = valid_q;
  assign status   = stat_q;
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
  import rxfs_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int CNT_W   = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_sof,
  input  logic       rx_eof,
  input  logic       rx_dribble,
  input  logic       rx_mii_err,
  input  logic       rx_buf_ovf,
  input  logic       rx_addr_match,
  input  logic       rx_addr_bcast,
  input  logic       rx_addr_mcast,
  input  logic       mon_mode,
  output logic       st_valid,
  output logic       st_bcast,
  output logic       st_mcast,
  output logic       st_missed,
  output logic       st_crc_err,
  output logic       st_align_err,
  output logic       st_intact
);
  logic             rst_int_n;
  logic             start, take, finish, err_next, ovf_next, crc_ok;
  logic [CNT_W-1:0] len_next;
  rxfs_status_t     status;

  rxfs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  rxfs_frame_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_int_n), .byte_vld(rx_valid), .sof(rx_sof), .eof(rx_eof),
    .mii_err(rx_mii_err), .buf_ovf(rx_buf_ovf), .start(start), .take(take),
    .finish(finish), .len_next(len_next), .err_next(err_next), .ovf_next(ovf_next)
  );

  rxfs_crc32 u_crc (
    .clk(clk), .rst_n(rst_int_n), .start(start), .take(take), .data(rx_data),
    .crc_ok(crc_ok)
  );

  rxfs_classify #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_cls (
    .clk(clk), .rst_n(rst_int_n), .start(start), .finish(finish), .len_next(len_next),
    .crc_ok(crc_ok), .err_seen(err_next), .ovf_seen(ovf_next), .dribble(rx_dribble),
    .addr_match(rx_addr_match), .addr_bcast(rx_addr_bcast), .addr_mcast(rx_addr_mcast),
    .mon_mode(mon_mode), .st_valid(st_valid), .status(status)
  );

  assign st_bcast     = status.bcast;
  assign st_mcast     = status.mcast;
  assign st_missed    = status.missed;
  assign st_crc_err   = status.crc_err;
  assign st_align_err = status.align_err;
  assign st_intact    = status.intact;
endmodule

// File: rtl/rxfs_checker.sv
module rxfs_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic rx_sof,
  input logic rx_eof,
  input logic rx_mii_err,
  input logic rx_buf_ovf,
  input logic rx_addr_bcast,
  input logic st_valid,
  input logic st_bcast,
  input logic st_mcast,
  input logic st_missed,
  input logic st_crc_err,
  input logic st_align_err,
  input logic st_intact
);
  logic any_flag;
  assign any_flag = st_bcast | st_mcast | st_missed | st_crc_err | st_align_err | st_intact;

  assert_strobe_follows_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(rx_valid && rx_eof));

  assert_flags_clear_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_valid && rx_sof && !rx_eof) |-> (!any_flag && !st_valid));

  assert_rx_err_forces_crc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && $past(rx_mii_err)) |-> st_crc_err);

  assert_align_needs_crc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_align_err |-> st_crc_err);

  assert_overflow_missed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && $past(rx_buf_ovf)) |-> st_missed);

  assert_intact_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_intact |-> (!st_crc_err && !st_missed));

  assert_bcast_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_bcast == $past(rx_addr_bcast)));
endmodule

bind rx_frame_status rxfs_checker u_rxfs_checker (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
  .rx_mii_err(rx_mii_err), .rx_buf_ovf(rx_buf_ovf), .rx_addr_bcast(rx_addr_bcast),
  .st_valid(st_valid), .st_bcast(st_bcast), .st_mcast(st_mcast), .st_missed(st_missed),
  .st_crc_err(st_crc_err), .st_align_err(st_align_err), .st_intact(st_intact)
);

// File: tb/tb_rx_frame_status.sv
module tb_rx_frame_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_dribble = 1'b0;
  logic rx_mii_err = 1'b0, rx_buf_ovf = 1'b0, rx_addr_match = 1'b0;
  logic rx_addr_bcast = 1'b0, rx_addr_mcast = 1'b0, mon_mode = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic st_valid, st_bcast, st_mcast, st_missed, st_crc_err, st_align_err, st_intact;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [7:0] fb [0:255];

  always #2 clk = ~clk;

  rx_frame_status dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_dribble(rx_dribble), .rx_mii_err(rx_mii_err),
    .rx_buf_ovf(rx_buf_ovf), .rx_addr_match(rx_addr_match), .rx_addr_bcast(rx_addr_bcast),
    .rx_addr_mcast(rx_addr_mcast), .mon_mode(mon_mode), .st_valid(st_valid),
    .st_bcast(st_bcast), .st_mcast(st_mcast), .st_missed(st_missed),
    .st_crc_err(st_crc_err), .st_align_err(st_align_err), .st_intact(st_intact)
  );

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ b[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic bit frame_crc_ok(input int len);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) r = crc_step(r, fb[i]);
    return r == 32'hDEBB20E3;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Fill fb with len bytes; if len >= 5 the last four are a correct FCS.
  task automatic build(input int len);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    if (len >= 5) begin
      for (int i = 0; i < len - 4; i++) r = crc_step(r, fb[i]);
      r = ~r;
      for (int k = 0; k < 4; k++) fb[len-4+k] = r[8*k +: 8];
    end
  endtask

  task automatic send(input int len, input int err_at, input int ovf_at, input bit drib,
                      input bit match, input bit bc, input bit mc, input bit mon,
                      input bit gaps);
    bit e_runt, e_crc, e_align, e_miss, e_int, seen_err, seen_ovf;
    seen_err = 0; seen_ovf = 0;
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom_range(0, 3) == 0)) begin
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_mii_err = 0; rx_buf_ovf = 0;
        rx_data = 8'($urandom);
        @(negedge clk);
      end
      rx_valid = 1; rx_data = fb[i]; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_mii_err = (i == err_at); rx_buf_ovf = (i == ovf_at);
      if (i == err_at) seen_err = 1;
      if (i == ovf_at) seen_ovf = 1;
      rx_dribble = drib; rx_addr_match = match; rx_addr_bcast = bc;
      rx_addr_mcast = mc; mon_mode = mon;
      @(negedge clk);
      if (i == 0 && len > 1) begin
        chk("R8 flags clear after start", st_crc_err | st_missed | st_intact |
            st_bcast | st_mcast | st_align_err, 1'b0);
      end
    end
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_mii_err = 0; rx_buf_ovf = 0;
    e_runt  = len < 64;
    e_crc   = seen_err || (!e_runt && !frame_crc_ok(len));
    e_align = e_crc && drib;
    e_miss  = seen_ovf || (match && mon && !e_runt && !e_crc);
    e_int   = match && !mon && !seen_ovf && !e_runt && !e_crc;
    chk("R8 valid strobe", st_valid, 1'b1);
    chk("R1/R2/R3 crc_err", st_crc_err, e_crc);
    chk("R4 align_err", st_align_err, e_align);
    chk("R5 missed", st_missed, e_miss);
    chk("R6 intact", st_intact, e_int);
    chk("R7 bcast", st_bcast, bc);
    chk("R7 mcast", st_mcast, mc);
    @(negedge clk);
    chk("R8 strobe one cycle", st_valid, 1'b0);
    chk("R8 flags held", st_crc_err, e_crc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R8 reset valid", st_valid, 1'b0);
    chk("R8 reset flags", st_crc_err | st_intact | st_missed, 1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: good 64-byte frame, recognized, normal mode -> intact
    build(64); send(64, -1, -1, 0, 1, 0, 0, 0, 0);
    chk("R1 good 64 intact", st_intact, 1'b1);
    // R1: one flipped bit at 64 bytes -> crc error, with dribble -> align (R4)
    build(64); fb[10] ^= 8'h04; send(64, -1, -1, 1, 1, 0, 0, 0, 0);
    chk("R4 align with crc", st_align_err, 1'b1);
    // R2: 63-byte corrupt frame -> runt hides crc mismatch
    build(63); fb[3] ^= 8'h80; send(63, -1, -1, 1, 1, 1, 0, 0, 0);
    chk("R2 runt no crc", st_crc_err, 1'b0);
    // R3: runt with receive error on start byte -> crc error
    build(20); send(20, 0, -1, 0, 1, 0, 1, 0, 0);
    chk("R3 err on runt", st_crc_err, 1'b1);
    // R3: receive error on end byte of good frame
    build(80); send(80, 79, -1, 0, 1, 0, 0, 0, 1);
    // R4: dribble without crc error -> no align error
    build(70); send(70, -1, -1, 1, 1, 0, 0, 0, 0);
    chk("R4 dribble alone", st_align_err, 1'b0);
    // R5: monitor mode, clean recognized frame -> missed, not intact
    build(64); send(64, -1, -1, 0, 1, 0, 1, 1, 1);
    chk("R5 monitor missed", st_missed, 1'b1);
    // R5: overflow mid-frame -> missed
    build(90); send(90, -1, 45, 0, 1, 0, 0, 0, 0);
    // R9: stray end marker and non-start bytes while idle do nothing
    rx_valid = 1; rx_eof = 1; rx_data = 8'h55; @(negedge clk);
    rx_eof = 0; @(negedge clk);
    rx_valid = 0; @(negedge clk);
    chk("R9 stray end ignored", st_valid, 1'b0);
    // R9: restart inside a frame
    build(30);
    for (int i = 0; i < 5; i++) begin
      rx_valid = 1; rx_sof = (i == 0); rx_data = fb[i]; @(negedge clk);
    end
    build(66); send(66, -1, -1, 0, 1, 0, 0, 0, 1);
    chk("R9 restart intact", st_intact, 1'b1);

    for (int n = 0; n < 300; n++) begin
      int len, ea, oa;
      len = ($urandom_range(0, 3) == 0) ? $urandom_range(62, 66) : $urandom_range(1, 140);
      build(len);
      if ($urandom_range(0, 3) == 0) fb[$urandom_range(0, len - 1)] ^= 8'(1 << $urandom_range(0, 7));
      ea = ($urandom_range(0, 7) == 0) ? $urandom_range(0, len - 1) : -1;
      oa = ($urandom_range(0, 7) == 0) ? $urandom_range(0, len - 1) : -1;
      send(len, ea, oa, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 3) == 0), 1'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule